// File: doc/BRIEF.md
# Register-Indirect Jump and Link Unit

This block resolves register-indirect jumps in a pipeline with one branch delay slot. When a jump is issued it takes the jump address from a source register value and checks that the address is word-aligned. If the address is good, the block marks the next instruction as a delay slot and holds the target in a register. The fetch logic takes the target from there once the slot instruction has executed. A misaligned address raises an address-fault flag instead of opening a slot.

The linking form also produces a return address. This is the program counter plus 8, wrapped to the counter width and sign-extended to the full register width. It goes out with a write enable and the fixed destination register index 31. The block also flags a jump that lands in another jump's delay slot, whether the slot comes from the block's own pending state or from the caller's slot input. Such a nested jump is not acted on. Register-file writes and instruction fetch are handled outside this block.

Top module: `jreg_link_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, the slot-pending output is 0 and the held target is 0.
- R2: A legal jump (issued, aligned, not nested) makes the slot-pending output 1 in the following cycle only. The flag is low again one cycle later.
- R3: After a legal jump the held target equals the full source value given with that jump. In all other cycles the target keeps its value.
- R4: A jump is misaligned when bits [1:0] of the source value are not both 0. It then raises the address-fault output in its own cycle, opens no delay slot and leaves the held target unchanged.
- R5: The linking jump (op code 2'b10) asserts the link write enable in its own cycle. The link value is pc+8 modulo 2^32, sign-extended from bit 31 to 64 bits, and the link destination is 31.
- R6: The plain jump (op code 2'b01) never asserts the link write enable.
- R7: A jump issued while the slot-pending output is 1, or while the slot input is 1, raises the nesting-fault output in its own cycle. It opens no slot and leaves the held target unchanged.
- R8: Op codes 2'b00 and 2'b11 are treated as no jump, and so is any op code with the issue input low. Such cycles raise no output flag and assert no link write.
- R9: A jump that is both misaligned and nested raises both fault outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 2 | 00 none, 01 plain jump, 10 linking jump, 11 none |
| pc_i | input | 32 | Program counter of the presented instruction |
| src_val_i | input | 64 | Source register value (the jump address) |
| in_slot_i | input | 1 | Presented instruction is known to be in a delay slot |
| target_o | output | 64 | Held jump target |
| slot_pending_o | output | 1 | The current instruction is a delay slot; redirect to target_o after it |
| link_we_o | output | 1 | Write the link value |
| link_val_o | output | 64 | Sign-extended return address |
| link_dst_o | output | 5 | Link destination register index (31) |
| addr_fault_o | output | 1 | Misaligned jump address |
| nest_fault_o | output | 1 | Jump inside a delay slot |

## Verification
The address fault and the nesting fault can occur in the same cycle. So can either fault and the link write. To provoke both faults at once, a misaligned jump is issued straight after a legal jump, and again with the slot input forced high. The result is judged by both flags being high while the pending flag and the held target are left exactly as the earlier legal jump set them. Random issue streams often put jumps back to back with random low address bits, so these overlaps also come up in large numbers against the bench model.

// File: rtl/jl_pkg.sv
package jl_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_JR   = 2'b01,
        OP_JALR = 2'b10,
        OP_RSVD = 2'b11
    } jl_op_e;

    // Per-cycle control decisions derived from the presented instruction
    typedef struct packed {
        logic jump;      // a jump of either form is issued
        logic link;      // linking form
        logic misalign;  // low address bits not zero
        logic nest;      // jump inside a delay slot
        logic start;     // legal jump: open slot and capture target
    } jl_ctl_t;

    localparam int unsigned LINK_OFFSET = 8;
    localparam logic [4:0]  LINK_REG    = 5'd31;

    function automatic logic op_is_jump(input logic [1:0] op);
        return (op == OP_JR) || (op == OP_JALR);
    endfunction

endpackage

// File: rtl/jl_decode.sv
module jl_decode
    import jl_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic                  issue_i,
    input  logic [1:0]            op_i,
    input  logic [ALIGN_BITS-1:0] addr_low_i,
    input  logic                  in_slot_i,
    input  logic                  pending_i,
    output jl_ctl_t               ctl_o
);
    always_comb begin
        ctl_o          = '0;
        ctl_o.jump     = issue_i && op_is_jump(op_i);
        ctl_o.link     = issue_i && (op_i == OP_JALR);
        ctl_o.misalign = ctl_o.jump && (|addr_low_i);
        ctl_o.nest     = ctl_o.jump && (in_slot_i || pending_i);
        ctl_o.start    = ctl_o.jump && !ctl_o.misalign && !ctl_o.nest;
    end
endmodule

// File: rtl/jl_link_gen.sv
module jl_link_gen
    import jl_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int XLEN = 64
) (
    input  logic [PC_W-1:0] pc_i,
    output logic [XLEN-1:0] link_o
);
    localparam int EXT_W = XLEN - PC_W;

    logic [PC_W-1:0] ret_addr;

    always_comb begin
        ret_addr = pc_i + PC_W'(LINK_OFFSET);
    end

    generate
        if (EXT_W > 0) begin : g_ext
            assign link_o = {{EXT_W{ret_addr[PC_W-1]}}, ret_addr};
        end else begin : g_noext
            assign link_o = ret_addr[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/jl_slot_track.sv
module jl_slot_track #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [XLEN-1:0] src_i,
    output logic            pending_o,
    output logic [XLEN-1:0] target_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            target_o  <= '0;
        end else begin
            pending_o <= start_i;
            if (start_i) begin
                target_o <= src_i;
            end
        end
    end
endmodule

// File: rtl/jreg_link_unit.sv
module jreg_link_unit
    import jl_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_i,
    input  logic [1:0]      op_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [XLEN-1:0] src_val_i,
    input  logic            in_slot_i,
    output logic [XLEN-1:0] target_o,
    output logic            slot_pending_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_val_o,
    output logic [4:0]      link_dst_o,
    output logic            addr_fault_o,
    output logic            nest_fault_o
);
    jl_ctl_t ctl;

    jl_decode #(.ALIGN_BITS(ALIGN_BITS)) u_dec (
        .issue_i    (issue_i),
        .op_i       (op_i),
        .addr_low_i (src_val_i[ALIGN_BITS-1:0]),
        .in_slot_i  (in_slot_i),
        .pending_i  (slot_pending_o),
        .ctl_o      (ctl)
    );

    jl_link_gen #(.PC_W(PC_W), .XLEN(XLEN)) u_link (
        .pc_i   (pc_i),
        .link_o (link_val_o)
    );

    jl_slot_track #(.XLEN(XLEN)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .start_i   (ctl.start),
        .src_i     (src_val_i),
        .pending_o (slot_pending_o),
        .target_o  (target_o)
    );

    assign link_we_o    = ctl.link;
    assign link_dst_o   = LINK_REG;
    assign addr_fault_o = ctl.misalign;
    assign nest_fault_o = ctl.nest;
endmodule

// File: rtl/jreg_link_unit_chk.sv
module jreg_link_unit_chk #(
    parameter int XLEN = 64,
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_i,
    input logic [1:0]      op_i,
    input logic [PC_W-1:0] pc_i,
    input logic [XLEN-1:0] src_val_i,
    input logic            in_slot_i,
    input logic [XLEN-1:0] target_o,
    input logic            slot_pending_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_val_o,
    input logic [4:0]      link_dst_o,
    input logic            addr_fault_o,
    input logic            nest_fault_o
);
    logic jump_now;
    logic legal_now;
    assign jump_now  = issue_i && (op_i == 2'b01 || op_i == 2'b10);
    assign legal_now = jump_now && !addr_fault_o && !nest_fault_o;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!slot_pending_o && target_o == '0));

    assert_slot_open_R2: assert property (@(posedge clk) disable iff (rst)
        legal_now |=> slot_pending_o);

    assert_slot_single_R2: assert property (@(posedge clk) disable iff (rst)
        slot_pending_o |=> !slot_pending_o);

    assert_target_capture_R3: assert property (@(posedge clk) disable iff (rst)
        legal_now |=> (target_o == $past(src_val_i)));

    assert_misalign_hold_R4: assert property (@(posedge clk) disable iff (rst)
        addr_fault_o |=> (!slot_pending_o && $stable(target_o)));

    assert_misalign_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (jump_now && src_val_i[1:0] != 2'b00) |-> addr_fault_o);

    assert_link_value_R5: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o[PC_W-1:0] == pc_i + PC_W'(8)
                       && link_val_o[XLEN-1:PC_W] == {(XLEN-PC_W){link_val_o[PC_W-1]}}
                       && link_dst_o == 5'd31));

    assert_plain_nolink_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b01) |-> !link_we_o);

    assert_nest_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (jump_now && (in_slot_i || slot_pending_o)) |-> nest_fault_o);

    assert_nest_hold_R7: assert property (@(posedge clk) disable iff (rst)
        nest_fault_o |=> (!slot_pending_o && $stable(target_o)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !jump_now |-> (!link_we_o && !addr_fault_o && !nest_fault_o));
endmodule

bind jreg_link_unit jreg_link_unit_chk #(.XLEN(XLEN), .PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .issue_i        (issue_i),
    .op_i           (op_i),
    .pc_i           (pc_i),
    .src_val_i      (src_val_i),
    .in_slot_i      (in_slot_i),
    .target_o       (target_o),
    .slot_pending_o (slot_pending_o),
    .link_we_o      (link_we_o),
    .link_val_o     (link_val_o),
    .link_dst_o     (link_dst_o),
    .addr_fault_o   (addr_fault_o),
    .nest_fault_o   (nest_fault_o)
);

// File: tb/jreg_link_unit_test.sv
module jreg_link_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] pc_i = '0;
    logic [63:0] src_val_i = '0;
    logic        in_slot_i = 1'b0;
    logic [63:0] target_o;
    logic        slot_pending_o;
    logic        link_we_o;
    logic [63:0] link_val_o;
    logic [4:0]  link_dst_o;
    logic        addr_fault_o;
    logic        nest_fault_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        exp_pend = 1'b0;
    logic [63:0] exp_tgt  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jreg_link_unit uut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .pc_i(pc_i),
        .src_val_i(src_val_i), .in_slot_i(in_slot_i), .target_o(target_o),
        .slot_pending_o(slot_pending_o), .link_we_o(link_we_o),
        .link_val_o(link_val_o), .link_dst_o(link_dst_o),
        .addr_fault_o(addr_fault_o), .nest_fault_o(nest_fault_o)
    );

    function automatic logic [63:0] ref_link(input logic [31:0] pc);
        logic [31:0] r;
        r = pc + 32'd8;
        return {{32{r[31]}}, r};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, check all outputs, advance the reference model.
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] pc,
                        input logic [63:0] src, input bit slot);
        bit jump, link, mis, nest, start;
        @(negedge clk);
        issue_i = v; op_i = op; pc_i = pc; src_val_i = src; in_slot_i = slot;
        #1;
        jump  = v && (op == 2'b01 || op == 2'b10);
        link  = v && (op == 2'b10);
        mis   = jump && (src[1:0] != 2'b00);
        nest  = jump && (slot || exp_pend);
        start = jump && !mis && !nest;
        chk(slot_pending_o == exp_pend, "R2", 64'(slot_pending_o), 64'(exp_pend));
        chk(target_o == exp_tgt, "R3", target_o, exp_tgt);
        chk(addr_fault_o == mis, "R4", 64'(addr_fault_o), 64'(mis));
        chk(nest_fault_o == nest, "R7", 64'(nest_fault_o), 64'(nest));
        if (link) begin
            chk(link_we_o == 1'b1, "R5", 64'(link_we_o), 64'd1);
            chk(link_val_o == ref_link(pc), "R5", link_val_o, ref_link(pc));
            chk(link_dst_o == 5'd31, "R5", 64'(link_dst_o), 64'd31);
        end else begin
            chk(link_we_o == 1'b0, (op == 2'b01) ? "R6" : "R8", 64'(link_we_o), 64'd0);
        end
        exp_pend = start;
        if (start) exp_tgt = src;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(slot_pending_o == 1'b0, "R1", 64'(slot_pending_o), 64'd0);
        chk(target_o == 64'd0, "R1", target_o, 64'd0);
        rst = 1'b0;
        step(0, 2'b00, 32'h0, 64'h0, 0);
        chk(target_o == 64'd0, "R1", target_o, 64'd0);

        // R2/R3: legal plain jump, full 64-bit target
        step(1, 2'b01, 32'h100, 64'hDEAD_BEEF_0000_1230, 0);
        // R7, R9: nested and misaligned linking jump in the slot
        step(1, 2'b10, 32'h104, 64'h0000_0000_0000_0003, 0);
        step(0, 2'b00, 32'h108, 64'h0, 0);
        // R4: misaligned, no slot
        step(1, 2'b01, 32'h200, 64'h0000_0000_0000_4002, 0);
        step(0, 2'b00, 32'h204, 64'h0, 0);
        // R5: link sign extension corners
        step(1, 2'b10, 32'h7FFF_FFFC, 64'h0000_0000_0000_0040, 0);
        step(0, 2'b00, 32'h0, 64'h0, 0);
        step(1, 2'b10, 32'hFFFF_FFF8, 64'h0000_0000_0000_0080, 0);
        step(0, 2'b00, 32'h0, 64'h0, 0);
        // R7 via slot input, R9 with misalignment too
        step(1, 2'b01, 32'h300, 64'h0000_0000_0000_0500, 1);
        step(1, 2'b10, 32'h304, 64'h0000_0000_0000_0501, 1);
        // R8: reserved op and unissued jump do nothing
        step(1, 2'b11, 32'h400, 64'h0000_0000_0000_0600, 0);
        step(0, 2'b01, 32'h404, 64'h0000_0000_0000_0700, 0);
        step(0, 2'b00, 32'h408, 64'h0, 0);
        chk(target_o == 64'h40 * 2, "R8", target_o, 64'h80);
        // R9 explicit: both flags at once after a legal jump
        step(1, 2'b01, 32'h500, 64'h0000_0000_0000_0900, 0);
        step(1, 2'b01, 32'h504, 64'h0000_0000_0000_0902, 0);
        chk(addr_fault_o && nest_fault_o, "R9", {62'd0, addr_fault_o, nest_fault_o}, 64'd3);
        step(0, 2'b00, 32'h508, 64'h0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [63:0] s;
            s = {$urandom, $urandom};
            step(($urandom % 4) != 0, 2'($urandom), $urandom, s,
                 ($urandom % 8) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule